// File: doc/BRIEF.md
# Asynchronous Serial Character Transceiver

This block moves characters between a parallel byte interface and a pair of serial lines, one outbound and one inbound, both working at the same time. Every bit on the line lasts a chosen number of pulses of an oversampling enable (`tick`) supplied from outside. Configuration inputs choose the character length, the parity mode, the number of stop bits and the clock factor. These inputs are meant to be set while both directions are idle.

The transmit side takes a byte over a valid/ready handshake and shifts it out, least significant bit first. A break input forces the outbound line low for as long as it is held. The receive side finds the falling edge of a start bit and confirms it at mid-bit. It samples each bit at its centre, then presents the character in a one-deep holding register together with its parity, framing and overrun flags. It also recognises a break on the inbound line, reporting when the break begins and when it ends.

Top module: `async_char_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, and `rx_avail`, `rx_brk` and the three error flags are 0.
- R2: A transmitted frame has a low start bit, then the data bits LSB first, then the parity bit if enabled, then the stop time at high level. Each bit lasts F ticks, where `cfg_clk` 0/1/2/3 gives F = 1/16/32/64. The line idles high.
- R3: `cfg_len` 0/1/2/3 selects 5/6/7/8 data bits. The transmitter ignores unused high bits of `tx_data`, and the receiver returns them as 0 in `rx_data`.
- R4: `cfg_stop` 0 gives a stop time of F ticks, and 2 or 3 gives 2F ticks. A value of 1 gives F + F/2 ticks, except at F = 1, where it gives 2 ticks.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` 0 it makes the count of ones in data plus parity even; with `cfg_par_odd` 1 it makes that count odd.
- R6: `tx_ready` is 1 exactly when the transmitter is idle and `tx_break` is 0. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are 1. The start bit appears on `txd` and `tx_ready` falls in the following cycle.
- R7: While `tx_break` is 1, `txd` is 0 and `tx_ready` is 0.
- R8: The receiver registers `rxd` through two flip-flops. For F of 16 or more, a low seen on a tick is accepted as a start bit only if the line is still low F/2 ticks later; each further bit is then sampled every F ticks. For F = 1, the data bits are sampled on the ticks that follow the low tick.
- R9: When the first stop bit is sampled, the character is loaded and `rx_avail` goes to 1. A one-cycle pulse on `rx_read` clears `rx_avail`.
- R10: `rx_par_err` is 1 for a loaded character whose received parity bit does not match the enabled parity mode.
- R11: `rx_frm_err` is 1 for a loaded character whose first stop bit was sampled low.
- R12: `rx_ovr` is 1 for a loaded character that arrived while `rx_avail` was still 1 and was not being cleared. Otherwise it is 0.
- R13: A frame whose data bits, parity bit and stop bit are all low is treated as a break and no character is loaded. At that point `rx_brk_start` pulses and `rx_brk` is set. When the line is next sampled high, `rx_brk_end` pulses and `rx_brk` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling enable, at most one cycle wide |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_stop | input | 2 | Stop time code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_clk | input | 2 | Clock factor code |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter will take a byte |
| tx_break | input | 1 | Force outbound line low |
| txd | output | 1 | Outbound serial line |
| rxd | input | 1 | Inbound serial line |
| rx_data | output | 8 | Last received character |
| rx_avail | output | 1 | Character waiting to be read |
| rx_read | input | 1 | Consume the waiting character |
| rx_par_err | output | 1 | Parity error on the held character |
| rx_frm_err | output | 1 | Framing error on the held character |
| rx_ovr | output | 1 | Held character overwrote an unread one |
| rx_brk | output | 1 | Break in progress on the inbound line |
| rx_brk_start | output | 1 | One-cycle pulse when a break is recognised |
| rx_brk_end | output | 1 | One-cycle pulse when a break ends |

## Verification
The assertions take for granted four things about the inputs: `tick` is high for at most one cycle at a time, ticks are spaced wider than the two-stage input synchroniser, the configuration does not change while a frame is in flight, and `rx_read` is a single-cycle pulse. The stimulus keeps within these limits in the following way. It issues a tick on every fourth clock, changes configuration only after both directions have settled, and pulses the read strobe for exactly one cycle. A behavioural model predicts the outbound line and the ready flag on every clock. Received characters are compared with the bytes that were sent or with frames driven directly onto the inbound line.

// File: rtl/acx_pkg.sv
package acx_pkg;

    localparam int ACX_CNT_W = 8;
    localparam int ACX_MAX_LEN = 8;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK} rx_st_e;

    // ticks per bit for each clock factor code
    function automatic logic [7:0] bit_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd1;
            2'd1:    return 8'd16;
            2'd2:    return 8'd32;
            default: return 8'd64;
        endcase
    endfunction

    // ticks spent in the stop interval
    function automatic logic [7:0] stop_ticks(input logic [1:0] fcode, input logic [1:0] scode);
        logic [7:0] f;
        f = bit_ticks(fcode);
        case (scode)
            2'd0:    return f;
            2'd1:    return (f == 8'd1) ? 8'd2 : f + (f >> 1);
            default: return f << 1;
        endcase
    endfunction

    function automatic logic [2:0] last_index(input logic [1:0] len_code);
        return 3'd4 + {1'b0, len_code};
    endfunction

endpackage

// File: rtl/acx_sync.sv
module acx_sync #(
    parameter int STAGES = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= {STAGES{RESET_VAL}};
        else     sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/acx_tx.sv
module acx_tx
    import acx_pkg::*;
#(
    parameter int CNT_W = ACX_CNT_W,
    parameter int DW = ACX_MAX_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [1:0]    cfg_clk,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          tx_break,
    output logic          txd
);
    typedef struct packed {
        tx_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]      idx;
        logic [DW-1:0]   shreg;
        logic            par;
        logic            line;
    } tx_s;

    tx_s q, d;
    logic [CNT_W-1:0] fbit, fstop;
    logic             bit_end;

    always_comb begin
        fbit    = CNT_W'(bit_ticks(cfg_clk));
        fstop   = CNT_W'(stop_ticks(cfg_clk, cfg_stop));
        bit_end = (q.cnt == fbit - 1'b1);
        tx_ready = (q.st == TX_IDLE) && !tx_break;
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (tx_valid && tx_ready) begin
                    d.st    = TX_START;
                    d.cnt   = '0;
                    d.idx   = '0;
                    d.shreg = tx_data;
                    d.par   = cfg_par_odd;
                    d.line  = 1'b0;
                end
            end
            TX_START: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.st   = TX_DATA;
                        d.line = q.shreg[0];
                        d.par  = q.par ^ q.shreg[0];
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            TX_DATA: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt = '0;
                        if (q.idx == last_index(cfg_len)) begin
                            if (cfg_par_en) begin
                                d.st   = TX_PAR;
                                d.line = q.par;
                            end else begin
                                d.st   = TX_STOP;
                                d.line = 1'b1;
                            end
                        end else begin
                            d.idx   = q.idx + 1'b1;
                            d.shreg = q.shreg >> 1;
                            d.line  = q.shreg[1];
                            d.par   = q.par ^ q.shreg[1];
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            TX_PAR: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.st   = TX_STOP;
                        d.line = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == fstop - 1'b1) begin
                        d.cnt = '0;
                        d.st  = TX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= TX_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.shreg <= '0;
            q.par   <= 1'b0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd = q.line & ~tx_break;

    AST_READY_MEANS_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);                                         // R6
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);                     // R6
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);                          // R2
endmodule

// File: rtl/acx_rx.sv
module acx_rx
    import acx_pkg::*;
#(
    parameter int CNT_W = ACX_CNT_W,
    parameter int DW = ACX_MAX_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [1:0]    cfg_clk,
    input  logic          rxs,
    input  logic          rx_read,
    output logic [DW-1:0] rx_data,
    output logic          rx_avail,
    output logic          rx_par_err,
    output logic          rx_frm_err,
    output logic          rx_ovr,
    output logic          rx_brk,
    output logic          rx_brk_start,
    output logic          rx_brk_end
);
    typedef struct packed {
        rx_st_e           st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [DW-1:0]    acc;
        logic             pacc;
        logic             pbit;
        logic [DW-1:0]    hold;
        logic             avail;
        logic             perr;
        logic             ferr;
        logic             ovr;
        logic             brk;
        logic             brk_start;
        logic             brk_end;
    } rx_s;

    rx_s q, d;
    logic [CNT_W-1:0] fbit;
    logic             bit_end;

    always_comb begin
        fbit    = CNT_W'(bit_ticks(cfg_clk));
        bit_end = (q.cnt == fbit - 1'b1);
        d = q;
        d.brk_start = 1'b0;
        d.brk_end   = 1'b0;
        if (rx_read) d.avail = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (tick && !rxs) begin
                    d.cnt  = '0;
                    d.idx  = '0;
                    d.acc  = '0;
                    d.pacc = cfg_par_odd;
                    d.pbit = 1'b0;
                    d.st   = (fbit == 1) ? RX_DATA : RX_START;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == (fbit >> 1) - 1'b1) begin
                        d.cnt = '0;
                        d.st  = rxs ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt          = '0;
                        d.acc[q.idx]   = rxs;
                        d.pacc         = q.pacc ^ rxs;
                        if (q.idx == last_index(cfg_len))
                            d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        else
                            d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.pbit = rxs;
                        d.st   = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt = '0;
                        if (!rxs && q.acc == '0 && !q.pbit) begin
                            d.brk       = 1'b1;
                            d.brk_start = 1'b1;
                            d.st        = RX_BRK;
                        end else begin
                            d.hold  = q.acc;
                            d.avail = 1'b1;
                            d.perr  = cfg_par_en && (q.pbit != q.pacc);
                            d.ferr  = !rxs;
                            d.ovr   = q.avail && !rx_read;
                            d.st    = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick && rxs) begin
                    d.brk     = 1'b0;
                    d.brk_end = 1'b1;
                    d.st      = RX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st        <= RX_IDLE;
            q.cnt       <= '0;
            q.idx       <= '0;
            q.acc       <= '0;
            q.pacc      <= 1'b0;
            q.pbit      <= 1'b0;
            q.hold      <= '0;
            q.avail     <= 1'b0;
            q.perr      <= 1'b0;
            q.ferr      <= 1'b0;
            q.ovr       <= 1'b0;
            q.brk       <= 1'b0;
            q.brk_start <= 1'b0;
            q.brk_end   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rx_data      = q.hold;
    assign rx_avail     = q.avail;
    assign rx_par_err   = q.perr;
    assign rx_frm_err   = q.ferr;
    assign rx_ovr       = q.ovr;
    assign rx_brk       = q.brk;
    assign rx_brk_start = q.brk_start;
    assign rx_brk_end   = q.brk_end;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_read && !tick) |=> !rx_avail);                         // R9
    AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> $past(rx_avail));                        // R12
    AST_BRK_START_SETS: assert property (@(posedge clk) disable iff (rst)
        rx_brk_start |-> rx_brk);                                  // R13
    AST_NO_LOAD_IN_BRK: assert property (@(posedge clk) disable iff (rst)
        rx_brk |-> !$rose(rx_avail));                              // R13
    AST_BRK_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rx_brk_start && rx_brk_end));                            // R13
endmodule

// File: rtl/async_char_xcvr.sv
module async_char_xcvr
    import acx_pkg::*;
#(
    parameter int CNT_W = ACX_CNT_W,
    parameter int SYNC_STAGES = 2,
    localparam int DW = ACX_MAX_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [1:0]    cfg_clk,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          tx_break,
    output logic          txd,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_avail,
    input  logic          rx_read,
    output logic          rx_par_err,
    output logic          rx_frm_err,
    output logic          rx_ovr,
    output logic          rx_brk,
    output logic          rx_brk_start,
    output logic          rx_brk_end
);
    logic rx_sync;

    acx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_sync)
    );

    acx_tx #(.CNT_W(CNT_W), .DW(DW)) u_tx (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_clk(cfg_clk),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_break(tx_break), .txd(txd)
    );

    acx_rx #(.CNT_W(CNT_W), .DW(DW)) u_rx (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_clk(cfg_clk), .rxs(rx_sync), .rx_read(rx_read),
        .rx_data(rx_data), .rx_avail(rx_avail), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_ovr(rx_ovr), .rx_brk(rx_brk),
        .rx_brk_start(rx_brk_start), .rx_brk_end(rx_brk_end)
    );
endmodule

// File: tb/tb_async_char_xcvr.sv
`timescale 1ns/1ps
module tb_async_char_xcvr;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0, cfg_clk = 2'd1;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0, tx_break = 1'b0, rx_read = 1'b0;
    logic loop = 1'b1, rxd_drv = 1'b1;
    logic tx_ready, txd, rx_avail, rx_par_err, rx_frm_err, rx_ovr;
    logic rx_brk, rx_brk_start, rx_brk_end;
    logic [7:0] rx_data;
    logic rxd_w;
    int total = 0, bad = 0;
    int brk_s_cnt = 0, brk_e_cnt = 0;
    int div = 0;

    always #2 clk = ~clk;  // 250 MHz

    assign rxd_w = loop ? txd : rxd_drv;

    async_char_xcvr dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_clk(cfg_clk),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_break(tx_break), .txd(txd), .rxd(rxd_w), .rx_data(rx_data),
        .rx_avail(rx_avail), .rx_read(rx_read), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_ovr(rx_ovr), .rx_brk(rx_brk),
        .rx_brk_start(rx_brk_start), .rx_brk_end(rx_brk_end)
    );

    // tick on every fourth clock
    always @(negedge clk) begin
        div  <= (div == 3) ? 0 : div + 1;
        tick <= (div == 3);
    end

    always @(posedge clk) begin
        if (!rst && rx_brk_start) brk_s_cnt++;
        if (!rst && rx_brk_end)   brk_e_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int fac(input logic [1:0] c);
        return (c == 0) ? 1 : (c == 1) ? 16 : (c == 2) ? 32 : 64;
    endfunction

    // behavioural model of the outbound line, one level per tick
    int lv[0:2047];
    int m_n, m_k, m_p;
    bit m_busy = 0, m_line = 1;

    task automatic push(input int v, input int cnt);
        for (int t = 0; t < cnt; t++) begin lv[m_p] = v; m_p++; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_line = 1;
        end else if (!m_busy && tx_valid && !tx_break) begin
            int f, pv, s;
            f = fac(cfg_clk);
            m_p = 0;
            push(0, f);
            pv = cfg_par_odd;
            for (int i = 0; i < 5 + cfg_len; i++) begin
                push(tx_data[i], f);
                pv ^= tx_data[i];
            end
            if (cfg_par_en) push(pv, f);
            s = (cfg_stop == 0) ? f : (cfg_stop == 1) ? ((f == 1) ? 2 : f + f / 2) : 2 * f;
            push(1, s);
            m_n = m_p; m_k = 0; m_busy = 1; m_line = lv[0][0];
        end else if (m_busy && tick) begin
            m_k++;
            if (m_k == m_n) begin m_busy = 0; m_line = 1; end
            else m_line = lv[m_k][0];
        end
    end

    // per-clock comparison of line and ready (R2 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (!rst) begin
            chk(txd === (m_line & ~tx_break), "R2_line", txd, m_line & ~tx_break);
            chk(tx_ready === (!m_busy && !tx_break), "R6_ready", tx_ready, !m_busy && !tx_break);
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (!tick);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(!tx_ready, "R6_drop", tx_ready, 0);
        while (!tx_ready) @(negedge clk);
        wait_ticks(3);
    endtask

    task automatic do_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
        chk(!rx_avail, "R9_clear", rx_avail, 0);
    endtask

    task automatic expect_rx(input string req, input logic [7:0] d,
                             input bit pe, input bit fe, input bit ov);
        chk(rx_avail === 1'b1, req, rx_avail, 1);
        chk(rx_data === d, req, rx_data, d);
        chk(rx_par_err === pe, {req, "_par"}, rx_par_err, pe);
        chk(rx_frm_err === fe, {req, "_frm"}, rx_frm_err, fe);
        chk(rx_ovr === ov, {req, "_ovr"}, rx_ovr, ov);
    endtask

    task automatic loop_char(input string req, input logic [7:0] b);
        logic [7:0] m;
        m = b & ((8'd1 << (5 + cfg_len)) - 8'd1);
        send(b);
        expect_rx(req, m, 0, 0, 0);
        do_read();
    endtask

    // drive one x16 frame directly onto the inbound line
    task automatic drive_frame(input logic [7:0] b, input bit pbit, input bit stopv);
        rxd_drv = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin rxd_drv = b[i]; wait_ticks(16); end
        rxd_drv = pbit; wait_ticks(16);
        rxd_drv = stopv; wait_ticks(16);
        rxd_drv = 1'b1; wait_ticks(40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1_txd", txd, 1);
        chk(tx_ready === 1'b1, "R1_ready", tx_ready, 1);
        chk(rx_avail === 1'b0, "R1_avail", rx_avail, 0);
        chk(rx_brk === 1'b0, "R1_brk", rx_brk, 0);
        chk({rx_par_err, rx_frm_err, rx_ovr} === 3'b000, "R1_flags", {rx_par_err, rx_frm_err, rx_ovr}, 0);

        // R2 8N1 at x16
        loop_char("R2_8n1", 8'hA5);
        // R3 R4 R8: 5 bits even parity two stops at x1
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_stop = 2'd2; cfg_clk = 2'd0;
        loop_char("R3_5bit", 8'hFF);
        loop_char("R8_x1", 8'h0B);
        // R4 R5: 7 bits odd parity 1.5 stops at x32, zero data with parity high
        cfg_len = 2'd2; cfg_par_odd = 1'b1; cfg_stop = 2'd1; cfg_clk = 2'd2;
        loop_char("R5_odd", 8'h55);
        loop_char("R5_zero", 8'h80);
        // R4: 1.5 stops at x1
        cfg_len = 2'd1; cfg_par_odd = 1'b0; cfg_clk = 2'd0;
        loop_char("R4_x1", 8'h2C);
        // R2: 8 bits at x64, stop code 3
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 2'd3; cfg_clk = 2'd3;
        loop_char("R2_x64", 8'h3C);

        // R12 overrun
        cfg_stop = 2'd0; cfg_clk = 2'd1;
        send(8'h11);
        expect_rx("R9_first", 8'h11, 0, 0, 0);
        send(8'h22);
        expect_rx("R12_ovr", 8'h22, 0, 0, 1);
        do_read();
        loop_char("R12_clear", 8'h33);

        // R7 R13 break
        @(negedge clk); tx_break = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R7_low", txd, 0);
        chk(tx_ready === 1'b0, "R7_ready", tx_ready, 0);
        wait_ticks(480);
        chk(brk_s_cnt == 1, "R13_start", brk_s_cnt, 1);
        chk(rx_brk === 1'b1, "R13_level", rx_brk, 1);
        chk(rx_avail === 1'b0, "R13_noload", rx_avail, 0);
        tx_break = 1'b0;
        wait_ticks(24);
        chk(brk_e_cnt == 1, "R13_end", brk_e_cnt, 1);
        chk(rx_brk === 1'b0, "R13_clear", rx_brk, 0);
        chk(rx_avail === 1'b0, "R13_noload2", rx_avail, 0);

        // directly driven inbound frames, 8 bits even parity x16
        loop = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        wait_ticks(4);
        drive_frame(8'h5A, 1'b1, 1'b1);
        expect_rx("R10_perr", 8'h5A, 1, 0, 0);
        do_read();
        drive_frame(8'h5A, 1'b0, 1'b0);
        expect_rx("R11_ferr", 8'h5A, 0, 1, 0);
        do_read();
        // R8: a low glitch shorter than half a bit is not a start bit
        rxd_drv = 1'b0; wait_ticks(4);
        rxd_drv = 1'b1; wait_ticks(220);
        chk(rx_avail === 1'b0, "R8_glitch", rx_avail, 0);
        chk(brk_s_cnt == 1, "R8_glitch_brk", brk_s_cnt, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule